// File: doc/BRIEF.md
# Burst Packet Transmit Engine

This block accepts a packet from a slow host and sends it as a short burst at a fixed fast bit rate. The host raises a chip-enable line and clocks in the bits one at a time on a serial clock and data pair, at whatever pace it likes. The destination address comes first, then the payload. The block stores the bits as they arrive. When the checksum option is on, it also updates a CRC-16 with each bit, so no extra pass over the data is needed later.

The host's serial clock, data and enable lines all pass through two-flop synchronisers into the system clock domain. A bit is taken on each detected rising edge of the host clock. When the enable line falls, the block latches its configuration and becomes busy. It waits a fixed start-up delay, counted in system cycles. It then shifts out the frame on one serial output with a one-cycle strobe per bit, at a rate picked from two parameterised dividers. The frame is the address, then the payload, then the CRC when that option is on.

Top module: `burst_tx_engine`

## Requirements
- R1: A bit is stored only on a synchronised rising edge of `host_clk` while the engine is in its load phase. That phase starts when `ce_in` rises with `busy` low. Host clock pulses while `ce_in` stays low start no burst.
- R2: The frame length is `cfg_addr_bits + cfg_payload_bits`, clamped to MAX_BITS. The burst sends the first frame-length stored bits in load order: bit 0 is the first address bit.
- R3: With `cfg_crc_en` = 1, 16 CRC bits follow the last frame bit, MSB first. The CRC uses polynomial 0x1021 with initial value 0xFFFF, shifted MSB first over the frame bits. Each step is: feedback = crc[15] XOR bit, crc = (crc << 1) XOR (feedback ? 0x1021 : 0).
- R4: With `cfg_crc_en` = 0, exactly frame-length strobes are produced and nothing follows them.
- R5: The first `tx_strobe` comes exactly STARTUP_CYCLES + 3 system cycles after the first clock edge that sees `ce_in` low. The extra 3 cycles are for synchronisation and edge detection.
- R6: `tx_strobe` pulses are exactly DIV_FAST cycles apart when `cfg_rate_slow` = 0, and DIV_SLOW cycles apart when it is 1. `tx_bit` holds the current bit for the whole bit period.
- R7: A host clock edge in the load phase after MAX_BITS bits have been stored sets `overflow`. That bit is not stored. `overflow` stays set until the next load phase begins.
- R8: `busy` is high from 3 cycles after `ce_in` falls until the end of the last bit period. It goes low exactly one bit period after the last strobe.
- R9: While `busy` is high, `ce_in` and host clock activity change neither the stored packet nor the burst in progress.
- R10: Bits loaded beyond the frame length, but within MAX_BITS, are neither sent nor included in the CRC.
- R11: Outside a burst, `tx_strobe` and `tx_bit` are both low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ce_in | input | 1 | Host enable: high to load, falling edge starts the burst |
| host_clk | input | 1 | Host serial clock, asynchronous |
| host_data | input | 1 | Host serial data, sampled on host_clk rising |
| cfg_crc_en | input | 1 | Append CRC-16 to the burst |
| cfg_rate_slow | input | 1 | 0: DIV_FAST bit period, 1: DIV_SLOW bit period |
| cfg_addr_bits | input | ADDR_W | Address length in bits |
| cfg_payload_bits | input | PAY_W | Payload length in bits |
| tx_bit | output | 1 | Serial burst output |
| tx_strobe | output | 1 | One-cycle pulse at the start of each bit |
| busy | output | 1 | Waiting for start or sending |
| overflow | output | 1 | Sticky: more than MAX_BITS bits loaded |

## Verification
The bench builds the engine with STARTUP_CYCLES = 40, DIV_FAST = 4 and DIV_SLOW = 12, and keeps MAX_BITS at 256. The short delay and dividers make the exact start latency, the bit spacing and the end of `busy` cheap to count cycle by cycle. The full 256-bit store stays in place, so the overflow edge and the frame-length clamp (a 511-bit payload setting) are reached with real loads. A 40-cycle wait also leaves room to drive the enable and host clock during the busy period, which tests that such activity is ignored.

// File: rtl/burst_pkg.sv
package burst_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOAD = 2'd1,
        ST_WAIT = 2'd2,
        ST_SEND = 2'd3
    } burst_state_e;

    localparam logic [15:0] CRC_POLY = 16'h1021;
    localparam logic [15:0] CRC_SEED = 16'hFFFF;
    localparam int          CRC_LEN  = 16;

    function automatic logic [15:0] crc16_step(input logic [15:0] crc, input logic din);
        logic fb;
        fb = crc[15] ^ din;
        return {crc[14:0], 1'b0} ^ (fb ? CRC_POLY : 16'h0000);
    endfunction

endpackage

// File: rtl/bit_sync.sv
module bit_sync #(
    parameter int WIDTH  = 1,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stage_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                stage_q[s] <= '0;
            end else if (s == 0) begin
                stage_q[s] <= d;
            end else begin
                stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
            end
        end
    end

    assign q = stage_q[STAGES-1];
endmodule

// File: rtl/strobe_gen.sv
module strobe_gen #(
    parameter int DIV_FAST = 50,
    parameter int DIV_SLOW = 200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic slow,
    output logic tick_first,
    output logic tick_last
);
    localparam int DIV_MAX = (DIV_FAST > DIV_SLOW) ? DIV_FAST : DIV_SLOW;
    localparam int TW      = $clog2(DIV_MAX + 1);
    localparam logic [TW-1:0] LIM_FAST = TW'(DIV_FAST - 1);
    localparam logic [TW-1:0] LIM_SLOW = TW'(DIV_SLOW - 1);

    logic [TW-1:0] cnt_d, cnt_q;
    logic [TW-1:0] lim;

    always_comb begin
        lim        = slow ? LIM_SLOW : LIM_FAST;
        tick_first = run && (cnt_q == '0);
        tick_last  = run && (cnt_q == lim);
        if (!run || tick_last) begin
            cnt_d = '0;
        end else begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R6: the period counter never runs past the selected limit
    assert_period_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (cnt_q <= lim));

    // R6: inside a bit period the counter advances by one per cycle
    assert_period_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !tick_last) |=> (!run || cnt_q == $past(cnt_q) + 1'b1));
endmodule

// File: rtl/burst_tx_engine.sv
module burst_tx_engine
    import burst_pkg::*;
#(
    parameter int MAX_BITS       = 256,
    parameter int ADDR_W         = 6,
    parameter int PAY_W          = 9,
    parameter int STARTUP_CYCLES = 10100,
    parameter int DIV_FAST       = 50,
    parameter int DIV_SLOW       = 200,
    parameter int SYNC_STAGES    = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_in,
    input  logic              host_clk,
    input  logic              host_data,
    input  logic              cfg_crc_en,
    input  logic              cfg_rate_slow,
    input  logic [ADDR_W-1:0] cfg_addr_bits,
    input  logic [PAY_W-1:0]  cfg_payload_bits,
    output logic              tx_bit,
    output logic              tx_strobe,
    output logic              busy,
    output logic              overflow
);
    localparam int PTR_W = $clog2(MAX_BITS);
    localparam int CNT_W = PTR_W + 1;
    localparam int IDX_W = CNT_W + 1;
    localparam int SUM_W = ((ADDR_W > PAY_W) ? ADDR_W : PAY_W) + 2;
    localparam int DLY_W = $clog2(STARTUP_CYCLES + 1);
    localparam logic [CNT_W-1:0] MAX_C   = CNT_W'(MAX_BITS);
    localparam logic [DLY_W-1:0] DLY_END = DLY_W'(STARTUP_CYCLES - 1);

    typedef struct packed {
        burst_state_e          state;
        logic                  ce_prev;
        logic                  hclk_prev;
        logic [CNT_W-1:0]      cnt;
        logic [15:0]           crc;
        logic [MAX_BITS-1:0]   store;
        logic                  ovf;
        logic [CNT_W-1:0]      flen;
        logic                  crc_en;
        logic                  slow;
        logic [DLY_W-1:0]      dly;
        logic [IDX_W-1:0]      idx;
    } eng_regs_t;

    eng_regs_t r_d, r_q;

    logic [2:0] sync_q;
    logic       ce_s, hclk_s, data_s;
    logic       ce_rise, ce_fall, hclk_rise;
    logic [SUM_W-1:0] len_sum;
    logic [CNT_W-1:0] cfg_flen;
    logic [IDX_W-1:0] total_bits;
    logic       in_frame;
    logic       tick_first, tick_last;

    bit_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({ce_in, host_clk, host_data}),
        .q     (sync_q)
    );

    strobe_gen #(.DIV_FAST(DIV_FAST), .DIV_SLOW(DIV_SLOW)) u_strobe (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (r_q.state == ST_SEND),
        .slow       (r_q.slow),
        .tick_first (tick_first),
        .tick_last  (tick_last)
    );

    always_comb begin
        ce_s      = sync_q[2];
        hclk_s    = sync_q[1];
        data_s    = sync_q[0];
        ce_rise   = ce_s && !r_q.ce_prev;
        ce_fall   = !ce_s && r_q.ce_prev;
        hclk_rise = hclk_s && !r_q.hclk_prev;

        len_sum  = SUM_W'(cfg_addr_bits) + SUM_W'(cfg_payload_bits);
        cfg_flen = (len_sum > SUM_W'(MAX_BITS)) ? MAX_C : CNT_W'(len_sum);

        total_bits = IDX_W'(r_q.flen) + (r_q.crc_en ? IDX_W'(CRC_LEN) : '0);
        in_frame   = r_q.idx < IDX_W'(r_q.flen);

        r_d           = r_q;
        r_d.ce_prev   = ce_s;
        r_d.hclk_prev = hclk_s;

        unique case (r_q.state)
            ST_IDLE: begin
                if (ce_rise) begin
                    r_d.state = ST_LOAD;
                    r_d.cnt   = '0;
                    r_d.crc   = CRC_SEED;
                    r_d.ovf   = 1'b0;
                end
            end
            ST_LOAD: begin
                if (ce_fall) begin
                    r_d.state  = ST_WAIT;
                    r_d.dly    = '0;
                    r_d.flen   = cfg_flen;
                    r_d.crc_en = cfg_crc_en;
                    r_d.slow   = cfg_rate_slow;
                end else if (hclk_rise) begin
                    if (r_q.cnt < MAX_C) begin
                        r_d.store[r_q.cnt[PTR_W-1:0]] = data_s;
                        if (r_q.cnt < cfg_flen) begin
                            r_d.crc = crc16_step(r_q.crc, data_s);
                        end
                        r_d.cnt = r_q.cnt + 1'b1;
                    end else begin
                        r_d.ovf = 1'b1;
                    end
                end
            end
            ST_WAIT: begin
                if (r_q.dly == DLY_END) begin
                    r_d.state = ST_SEND;
                    r_d.idx   = '0;
                end else begin
                    r_d.dly = r_q.dly + 1'b1;
                end
            end
            ST_SEND: begin
                if (tick_last) begin
                    if (!in_frame) begin
                        r_d.crc = {r_q.crc[14:0], 1'b0};
                    end
                    if (r_q.idx == total_bits - 1'b1) begin
                        r_d.state = ST_IDLE;
                    end else begin
                        r_d.idx = r_q.idx + 1'b1;
                    end
                end
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q       <= '0;
            r_q.state <= ST_IDLE;
            r_q.crc   <= CRC_SEED;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        busy      = (r_q.state == ST_WAIT) || (r_q.state == ST_SEND);
        tx_strobe = (r_q.state == ST_SEND) && tick_first;
        overflow  = r_q.ovf;
        if (r_q.state != ST_SEND) begin
            tx_bit = 1'b0;
        end else if (in_frame) begin
            tx_bit = r_q.store[r_q.idx[PTR_W-1:0]];
        end else begin
            tx_bit = r_q.crc[15];
        end
    end

    // R11: a strobe is only ever seen during a burst
    assert_strobe_in_burst_R11: assert property (@(posedge clk) disable iff (!rst_n)
        tx_strobe |-> busy);

    // R7: overflow only clears at the start of a new load
    assert_overflow_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.ovf && !(r_q.state == ST_IDLE && ce_rise)) |=> r_q.ovf);

    // R8: busy drops only at the end of a bit period
    assert_busy_end_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(tick_last));

    // R5: the start-up wait is not cut short
    assert_wait_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_WAIT && r_q.dly != DLY_END) |=> (r_q.state == ST_WAIT));

    // R9: the stored packet is frozen while busy
    assert_store_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(r_q.store));
endmodule

// File: tb/burst_tx_engine_bench.sv
module burst_tx_engine_bench;
    localparam int STARTUP = 40;
    localparam int DFAST   = 4;
    localparam int DSLOW   = 12;
    localparam int MAXB    = 256;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ce_in = 1'b0, host_clk = 1'b0, host_data = 1'b0;
    logic cfg_crc_en = 1'b0, cfg_rate_slow = 1'b0;
    logic [5:0] cfg_addr_bits = '0;
    logic [8:0] cfg_payload_bits = '0;
    logic tx_bit, tx_strobe, busy, overflow;

    int errors = 0;
    int checks = 0;
    int cycles = 0;
    logic pkt [0:299];

    always #10 clk = ~clk;

    burst_tx_engine #(
        .MAX_BITS(MAXB), .ADDR_W(6), .PAY_W(9),
        .STARTUP_CYCLES(STARTUP), .DIV_FAST(DFAST), .DIV_SLOW(DSLOW)
    ) u_burst_tx_engine (
        .clk(clk), .rst_n(rst_n), .ce_in(ce_in), .host_clk(host_clk),
        .host_data(host_data), .cfg_crc_en(cfg_crc_en), .cfg_rate_slow(cfg_rate_slow),
        .cfg_addr_bits(cfg_addr_bits), .cfg_payload_bits(cfg_payload_bits),
        .tx_bit(tx_bit), .tx_strobe(tx_strobe), .busy(busy), .overflow(overflow)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic logic [15:0] model_crc(input int n);
        logic [15:0] c = 16'hFFFF;
        for (int i = 0; i < n; i++) begin
            if (c[15] ^ pkt[i]) c = (c << 1) ^ 16'h1021;
            else                c = c << 1;
        end
        return c;
    endfunction

    function automatic int clamp_len(input int a, input int p);
        return (a + p > MAXB) ? MAXB : a + p;
    endfunction

    task automatic fill_random();
        for (int i = 0; i < 300; i++) pkt[i] = 1'($urandom % 2);
    endtask

    task automatic load(input int nbits, input bit check_clear);
        ce_in = 1'b1;
        repeat (4) @(negedge clk);
        if (check_clear) check(overflow == 1'b0, "R7", "overflow cleared at load start", int'(overflow), 0);
        for (int i = 0; i < nbits; i++) begin
            host_data = pkt[i];
            repeat (3) @(negedge clk);
            host_clk = 1'b1;
            repeat (3) @(negedge clk);
            host_clk = 1'b0;
        end
        repeat (4) @(negedge clk);
    endtask

    // drops ce_in, then checks start delay, every bit, spacing and busy end
    task automatic burst(input int flen, input bit crc_on, input bit slow, input bit inject);
        int cyc = 0;
        int div = slow ? DSLOW : DFAST;
        int total = flen + (crc_on ? 16 : 0);
        logic [15:0] c = model_crc(flen);
        bit seen = 0;
        ce_in = 1'b0;
        while (!seen && cyc < STARTUP + 60) begin
            @(negedge clk);
            cyc++;
            if (cyc == 3) check(busy == 1'b1, "R8", "busy after enable fall", int'(busy), 1);
            if (inject) begin
                if (cyc == 4) ce_in = 1'b1;
                if (cyc >= 6 && cyc < 30) begin
                    host_clk  = cyc[1];
                    host_data = cyc[2];
                end
                if (cyc == 32) begin
                    ce_in = 1'b0;
                    host_clk = 1'b0;
                end
            end
            if (tx_strobe) seen = 1;
        end
        check(cyc == STARTUP + 3, "R5", "cycles to first strobe", cyc, STARTUP + 3);
        for (int i = 0; i < total; i++) begin
            logic exp = (i < flen) ? pkt[i] : c[15 - (i - flen)];
            check(tx_bit == exp, (i < flen) ? "R2" : "R3", $sformatf("bit %0d", i), int'(tx_bit), int'(exp));
            if (i < total - 1) begin
                int gap = 0;
                do begin
                    @(negedge clk);
                    gap++;
                    if (!tx_strobe && gap < div) begin
                        if (gap == 1 && tx_bit != exp)
                            check(0, "R6", "bit held across period", int'(tx_bit), int'(exp));
                    end
                end while (!tx_strobe && gap < 200);
                check(gap == div, "R6", "strobe spacing", gap, div);
            end
        end
        repeat (div - 1) @(negedge clk);
        check(busy == 1'b1, "R8", "busy through last period", int'(busy), 1);
        @(negedge clk);
        check(busy == 1'b0, "R8", "busy low after last period", int'(busy), 0);
        begin
            bit extra = 0;
            for (int k = 0; k < 3 * DSLOW; k++) begin
                @(negedge clk);
                if (tx_strobe || tx_bit) extra = 1;
            end
            check(!extra, crc_on ? "R11" : "R4", "quiet after burst", int'(extra), 0);
        end
    endtask

    task automatic packet(input int a, input int p, input bit crc_on, input bit slow,
                          input int extra, input bit inject);
        int flen = clamp_len(a, p);
        cfg_addr_bits = 6'(a);
        cfg_payload_bits = 9'(p);
        cfg_crc_en = crc_on;
        cfg_rate_slow = slow;
        fill_random();
        load(flen + extra, 1'b0);
        burst(flen, crc_on, slow, inject);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 200000) begin
                errors++;
                checks++;
                $display("FAIL watchdog: actual=%0d expected<=%0d", cycles, 200000);
                $display("Result: errors=%0d of %0d checks", errors, checks);
                $finish;
            end
        end
    end

    initial begin
        void'($urandom(32'h5EED_0021));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 and reset state
        check(busy == 0 && tx_strobe == 0 && tx_bit == 0, "R11", "reset outputs quiet",
              int'({busy, tx_strobe, tx_bit}), 0);
        check(overflow == 0, "R7", "overflow clear after reset", int'(overflow), 0);

        // R1: host clock with enable low starts nothing
        begin
            bit act = 0;
            for (int i = 0; i < 6; i++) begin
                host_data = 1'b1;
                repeat (3) @(negedge clk);
                host_clk = 1'b1;
                repeat (3) @(negedge clk);
                host_clk = 1'b0;
            end
            for (int k = 0; k < STARTUP + 20; k++) begin
                @(negedge clk);
                if (busy || tx_strobe) act = 1;
            end
            check(!act, "R1", "no burst without enable", int'(act), 0);
        end

        // directed: R2 R3 fast with CRC
        packet(8, 16, 1'b1, 1'b0, 0, 1'b0);
        // R4: no CRC, slow rate
        packet(40, 24, 1'b0, 1'b1, 0, 1'b0);
        // R10: extra bits beyond frame length
        packet(5, 7, 1'b1, 1'b0, 5, 1'b0);
        // R9: enable and host clock driven while busy
        packet(16, 32, 1'b1, 1'b1, 0, 1'b1);

        // R7 / R2 clamp: 511-bit payload clamps to 256, 262 bits loaded
        cfg_addr_bits = 6'd40;
        cfg_payload_bits = 9'd511;
        cfg_crc_en = 1'b1;
        cfg_rate_slow = 1'b0;
        fill_random();
        load(262, 1'b0);
        check(overflow == 1'b1, "R7", "overflow after 262 bits", int'(overflow), 1);
        burst(MAXB, 1'b1, 1'b0, 1'b0);
        check(overflow == 1'b1, "R7", "overflow sticky after burst", int'(overflow), 1);
        cfg_addr_bits = 6'd3;
        cfg_payload_bits = 9'd9;
        cfg_crc_en = 1'b0;
        fill_random();
        load(12, 1'b1);
        burst(12, 1'b0, 1'b0, 1'b0);

        // random packets
        for (int n = 0; n < 6; n++) begin
            packet(1 + int'($urandom % 40), 1 + int'($urandom % 64),
                   1'($urandom % 2), 1'($urandom % 2), int'($urandom % 3), 1'b0);
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule